// File: doc/BRIEF.md
# Reorder Buffer with Multi-Cycle Squash Walk

This block keeps the in-flight instructions of an out-of-order core in program order inside a circular buffer. Dispatch writes a new entry (sequence number, PC, next PC) at the tail and gets back the slot index it used. Execution marks a slot complete through that index. Commit looks at the head, sees whether it is ready, and pulses retire to free it. Occupancy, free count, full, empty and the head and tail fields are always visible.

A squash request names a boundary sequence number. Every entry younger than the boundary is thrown away, and the boundary entry itself stays. The buffer does not drop those entries in one cycle. A walk pointer starts at the youngest entry and moves toward the head, examining at most `SQ_WIDTH` entries per cycle and flagging each younger entry as squashed. The tail stays where it is during the walk. When the walk meets the first entry that is not younger, or runs out of entries, the flagged entries are reclaimed in a single step. The tail is pulled back and the occupancy drops in the same cycle, and the done flag rises again.

Top module: `rob_squash_walk`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `occupancy`=0, `free_cnt`=DEPTH, `squash_done`=1, `head_ready`=0.
- R2: `occupancy` counts the held entries, `free_cnt` equals DEPTH minus `occupancy`, `full` is 1 exactly when `occupancy`=DEPTH, and `empty` is 1 exactly when `occupancy`=0. The producer must not insert while `full` is 1, and the buffer never stalls it.
- R3: An accepted insert goes to the slot shown on `ins_slot` in the cycle it is presented. The tail fields then show that entry. Entries reach the head in insertion order, and each keeps its sequence number, PC and next PC.
- R4: `head_ready` is 1 only when the buffer is not empty and the head slot has been marked complete by a `cmpl_valid` pulse carrying that slot index. Completing any other slot leaves `head_ready` unchanged.
- R5: An accepted `retire` moves the head to the next entry and lowers `occupancy` by one. A `retire` while the buffer is empty is ignored: occupancy stays 0 and the next inserted entry appears at the head.
- R6: An insert and a retire accepted in the same cycle leave `occupancy` unchanged.
- R7: A squash with boundary B removes every entry whose sequence number is greater than B (unsigned compare, no wrap) and keeps every entry whose sequence number is B or less. Once `squash_done` is back at 1, `occupancy` and the tail fields describe the kept entries.
- R8: `squash_done` falls in the cycle after an accepted squash request and stays low for max(1, ceil(min(N+1, C)/SQ_WIDTH)) cycles, where C is the occupancy at the request and N the number of younger entries.
- R9: While `squash_done` is low, `tail_seq` and `tail_pc` keep their value from before the request. A younger tail entry shows `tail_squashed`=1 once the first walk cycle has passed. After reclaim the new tail shows `tail_squashed`=0.
- R10: Inserts, retires and further squash requests are ignored while `squash_done` is low. A squash request takes precedence over an insert or retire in the same cycle, which are then ignored.
- R11: A squash of an empty buffer, or one with no younger entry, completes after one low cycle of `squash_done` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_pc | input | PC_W | PC of the inserted instruction |
| ins_npc | input | PC_W | Next PC of the inserted instruction |
| ins_slot | output | log2(DEPTH) | Slot the next insert will use |
| cmpl_valid | input | 1 | Mark a slot complete |
| cmpl_slot | input | log2(DEPTH) | Slot to mark complete |
| retire | input | 1 | Retire the head entry |
| head_ready | output | 1 | Head entry present and complete |
| squash_req | input | 1 | Start a squash |
| squash_seq | input | SEQ_W | Boundary sequence number, kept |
| squash_done | output | 1 | No squash walk in progress |
| occupancy | output | log2(DEPTH+1) | Number of held entries |
| free_cnt | output | log2(DEPTH+1) | DEPTH minus occupancy |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| head_seq | output | SEQ_W | Sequence number at the head |
| head_pc | output | PC_W | PC at the head |
| head_npc | output | PC_W | Next PC at the head |
| tail_seq | output | SEQ_W | Sequence number of the youngest entry |
| tail_pc | output | PC_W | PC of the youngest entry |
| tail_squashed | output | 1 | Squash flag of the youngest entry |

## Verification
The bench builds the buffer with DEPTH=8 and SQ_WIDTH=2. The buffer can therefore be filled, and the head and tail wrapped, within a handful of inserts. A squash of five entries takes three walk cycles, so the middle of a walk can be observed, and the bench presents inserts and retires there that must be dropped. The narrow width also separates the cases that decide the walk length: stopping at a kept entry, running out of entries, and an empty buffer.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Step a ring index back by n positions (n no larger than depth).
  function automatic int ring_back(input int p, input int n, input int depth);
    int t;
    t = p - n;
    if (t < 0) t = t + depth;
    return t;
  endfunction

  // Step a ring index forward by one position.
  function automatic int ring_next(input int p, input int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/rob_payload_ram.sv
module rob_payload_ram #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [PC_W-1:0]          wpc,
  input  logic [PC_W-1:0]          wnpc,
  input  logic [$clog2(DEPTH)-1:0] head_addr,
  output logic [PC_W-1:0]          head_pc,
  output logic [PC_W-1:0]          head_npc,
  input  logic [$clog2(DEPTH)-1:0] tail_addr,
  output logic [PC_W-1:0]          tail_pc
);
  // Write-once-per-insert storage, no reset, so it maps to distributed RAM.
  logic [PC_W-1:0] pc_mem  [DEPTH];
  logic [PC_W-1:0] npc_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      pc_mem[waddr]  <= wpc;
      npc_mem[waddr] <= wnpc;
    end
  end

  assign head_pc  = pc_mem[head_addr];
  assign head_npc = npc_mem[head_addr];
  assign tail_pc  = pc_mem[tail_addr];
endmodule

// File: rtl/rob_walker.sv
module rob_walker #(
  parameter int DEPTH    = 16,
  parameter int SQ_WIDTH = 4,
  parameter int SEQ_W    = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  input  logic [$clog2(DEPTH)-1:0]             start_ptr,
  input  logic [$clog2(DEPTH+1)-1:0]           start_left,
  input  logic [SEQ_W-1:0]                     bound,
  input  logic [SQ_WIDTH-1:0][SEQ_W-1:0]       probe_seq,
  output logic [SQ_WIDTH-1:0][$clog2(DEPTH)-1:0] probe_idx,
  output logic [SQ_WIDTH-1:0]                  mark,
  output logic                                 finish,
  output logic [$clog2(DEPTH+1)-1:0]           drop_cnt,
  output logic                                 done
);
  import rob_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] PARK   = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] WIDTHC = CNT_W'(SQ_WIDTH);

  logic [CNT_W-1:0] ptr_q;    // entry to examine next, PARK when idle
  logic [CNT_W-1:0] left_q;   // entries not yet examined
  logic [CNT_W-1:0] total_q;  // entries flagged so far
  logic [SEQ_W-1:0] bound_q;
  logic [CNT_W-1:0] nyoung;
  logic             active;

  assign active = (ptr_q != PARK);
  assign done   = !active;

  generate
    for (genvar k = 0; k < SQ_WIDTH; k++) begin : g_probe
      assign probe_idx[k] = IDX_W'(ring_back(int'(ptr_q), k, DEPTH));
    end
  endgenerate

  // Leading run of younger entries among this cycle's probes.
  always_comb begin
    logic alive;
    alive  = 1'b1;
    nyoung = '0;
    for (int k = 0; k < SQ_WIDTH; k++) begin
      mark[k] = active && alive && (CNT_W'(k) < left_q) && (probe_seq[k] > bound_q);
      if (mark[k]) nyoung = nyoung + CNT_W'(1);
      else         alive  = 1'b0;
    end
  end

  assign finish   = active && ((nyoung < WIDTHC) || (nyoung == left_q));
  assign drop_cnt = total_q + nyoung;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= PARK;
      left_q  <= '0;
      total_q <= '0;
      bound_q <= '0;
    end else if (start) begin
      ptr_q   <= CNT_W'(start_ptr);
      left_q  <= start_left;
      total_q <= '0;
      bound_q <= bound;
    end else if (finish) begin
      ptr_q   <= PARK;
      left_q  <= '0;
      total_q <= '0;
    end else if (active) begin
      ptr_q   <= CNT_W'(ring_back(int'(ptr_q), int'(nyoung), DEPTH));
      left_q  <= left_q - nyoung;
      total_q <= total_q + nyoung;
    end
  end

  // R8
  start_lowers_done_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !done);

  // R8
  finish_parks_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> done);

  // R8
  walk_progress_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !start) |=> (left_q <= $past(left_q)));
endmodule

// File: rtl/rob_squash_walk.sv
module rob_squash_walk #(
  parameter int DEPTH    = 16,
  parameter int SQ_WIDTH = 4,
  parameter int SEQ_W    = 16,
  parameter int PC_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ins_valid,
  input  logic [SEQ_W-1:0]           ins_seq,
  input  logic [PC_W-1:0]            ins_pc,
  input  logic [PC_W-1:0]            ins_npc,
  output logic [$clog2(DEPTH)-1:0]   ins_slot,
  input  logic                       cmpl_valid,
  input  logic [$clog2(DEPTH)-1:0]   cmpl_slot,
  input  logic                       retire,
  output logic                       head_ready,
  input  logic                       squash_req,
  input  logic [SEQ_W-1:0]           squash_seq,
  output logic                       squash_done,
  output logic [$clog2(DEPTH+1)-1:0] occupancy,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt,
  output logic                       full,
  output logic                       empty,
  output logic [SEQ_W-1:0]           head_seq,
  output logic [PC_W-1:0]            head_pc,
  output logic [PC_W-1:0]            head_npc,
  output logic [SEQ_W-1:0]           tail_seq,
  output logic [PC_W-1:0]            tail_pc,
  output logic                       tail_squashed
);
  import rob_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [IDX_W-1:0] head_q, tail_q, last_idx;
  logic [CNT_W-1:0] cnt_q, cnt_nx, free_q;
  logic             full_q, empty_q;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [DEPTH-1:0] cmp_q, sqf_q;

  logic acc_sq, acc_ins, acc_ret;
  logic                            walk_done, walk_finish;
  logic [CNT_W-1:0]                walk_drop;
  logic [SQ_WIDTH-1:0]             walk_mark;
  logic [SQ_WIDTH-1:0][IDX_W-1:0]  walk_idx;
  logic [SQ_WIDTH-1:0][SEQ_W-1:0]  walk_seq;

  // Acceptance: a squash wins over insert and retire; all wait for the walk.
  assign acc_sq  = squash_req && walk_done;
  assign acc_ins = ins_valid && walk_done && !squash_req;
  assign acc_ret = retire && walk_done && !squash_req && !empty_q;

  assign last_idx = IDX_W'(ring_back(int'(tail_q), 1, DEPTH));

  generate
    for (genvar k = 0; k < SQ_WIDTH; k++) begin : g_seq_rd
      assign walk_seq[k] = seq_q[walk_idx[k]];
    end
  endgenerate

  rob_walker #(.DEPTH(DEPTH), .SQ_WIDTH(SQ_WIDTH), .SEQ_W(SEQ_W)) u_walker (
    .clk        (clk),
    .rst        (rst),
    .start      (acc_sq),
    .start_ptr  (last_idx),
    .start_left (cnt_q),
    .bound      (squash_seq),
    .probe_seq  (walk_seq),
    .probe_idx  (walk_idx),
    .mark       (walk_mark),
    .finish     (walk_finish),
    .drop_cnt   (walk_drop),
    .done       (walk_done)
  );

  rob_payload_ram #(.DEPTH(DEPTH), .PC_W(PC_W)) u_payload (
    .clk       (clk),
    .we        (acc_ins),
    .waddr     (tail_q),
    .wpc       (ins_pc),
    .wnpc      (ins_npc),
    .head_addr (head_q),
    .head_pc   (head_pc),
    .head_npc  (head_npc),
    .tail_addr (last_idx),
    .tail_pc   (tail_pc)
  );

  always_comb begin
    if (walk_finish) cnt_nx = cnt_q - walk_drop;
    else             cnt_nx = cnt_q + CNT_W'(acc_ins) - CNT_W'(acc_ret);
  end

  // Pointers and registered occupancy flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      free_q  <= CNT_FULL;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_nx;
      free_q  <= CNT_FULL - cnt_nx;
      full_q  <= (cnt_nx == CNT_FULL);
      empty_q <= (cnt_nx == '0);
      if (acc_ret) head_q <= IDX_W'(ring_next(int'(head_q), DEPTH));
      if (walk_finish)
        tail_q <= IDX_W'(ring_back(int'(tail_q), int'(walk_drop), DEPTH));
      else if (acc_ins)
        tail_q <= IDX_W'(ring_next(int'(tail_q), DEPTH));
    end
  end

  // Per-entry sequence numbers and flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      sqf_q <= '0;
      for (int i = 0; i < DEPTH; i++) seq_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (acc_ins && tail_q == IDX_W'(i)) begin
          seq_q[i] <= ins_seq;
          cmp_q[i] <= 1'b0;
          sqf_q[i] <= 1'b0;
        end else begin
          if (cmpl_valid && cmpl_slot == IDX_W'(i)) cmp_q[i] <= 1'b1;
          for (int k = 0; k < SQ_WIDTH; k++)
            if (walk_mark[k] && walk_idx[k] == IDX_W'(i)) sqf_q[i] <= 1'b1;
        end
      end
    end
  end

  assign ins_slot      = tail_q;
  assign head_ready    = !empty_q && cmp_q[head_q];
  assign squash_done   = walk_done;
  assign occupancy     = cnt_q;
  assign free_cnt      = free_q;
  assign full          = full_q;
  assign empty         = empty_q;
  assign head_seq      = seq_q[head_q];
  assign tail_seq      = seq_q[last_idx];
  assign tail_squashed = sqf_q[last_idx];

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ins |-> !full_q);

  // R2
  always_comb begin
    if (!rst) count_bound_chk: assert (cnt_q <= CNT_FULL);
  end

  // R5
  empty_retire_chk: assert property (@(posedge clk) disable iff (rst)
    (retire && empty_q && !ins_valid) |=> (cnt_q == '0) && $stable(head_q));

  // R9
  tail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!walk_done && !walk_finish) |=> $stable(tail_q) && $stable(cnt_q));

  // R10
  walk_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !walk_done |=> $stable(head_q));
endmodule

// File: tb/test_rob_squash_walk.sv
module test_rob_squash_walk;
  localparam int DEPTH = 8;
  localparam int SQW   = 2;
  localparam int SEQ_W = 16;
  localparam int PC_W  = 32;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst, ins_valid, cmpl_valid, retire, squash_req;
  logic [SEQ_W-1:0] ins_seq, squash_seq;
  logic [PC_W-1:0]  ins_pc, ins_npc;
  logic [IDX_W-1:0] ins_slot, cmpl_slot;
  logic             head_ready, squash_done, full, empty, tail_squashed;
  logic [CNT_W-1:0] occupancy, free_cnt;
  logic [SEQ_W-1:0] head_seq, tail_seq;
  logic [PC_W-1:0]  head_pc, head_npc, tail_pc;

  rob_squash_walk #(.DEPTH(DEPTH), .SQ_WIDTH(SQW), .SEQ_W(SEQ_W), .PC_W(PC_W)) i_rob_squash_walk (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_pc(ins_pc),
    .ins_npc(ins_npc), .ins_slot(ins_slot), .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot),
    .retire(retire), .head_ready(head_ready), .squash_req(squash_req), .squash_seq(squash_seq),
    .squash_done(squash_done), .occupancy(occupancy), .free_cnt(free_cnt), .full(full),
    .empty(empty), .head_seq(head_seq), .head_pc(head_pc), .head_npc(head_npc),
    .tail_seq(tail_seq), .tail_pc(tail_pc), .tail_squashed(tail_squashed));

  typedef struct {
    logic [SEQ_W-1:0] seq;
    logic [PC_W-1:0]  pc;
    logic [PC_W-1:0]  npc;
    logic [IDX_W-1:0] slot;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_err = 0;
  bit timed_out = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_of(input logic [SEQ_W-1:0] s);
    return 32'h4000 + 32'(s) * 4;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  // Monitor side of the scoreboard: compare the head with the oldest expected item.
  task automatic check_head();
    if (exp_q.size() > 0) begin
      chk("R3", "head_seq", head_seq, exp_q[0].seq);
      chk("R3", "head_pc", head_pc, exp_q[0].pc);
      chk("R3", "head_npc", head_npc, exp_q[0].npc);
    end
  endtask

  // Driver: present an insert (optionally with a retire) and push the expected item.
  task automatic ins(input logic [SEQ_W-1:0] s, input bit with_ret);
    item_t it;
    it.seq = s; it.pc = pc_of(s); it.npc = pc_of(s) + 4; it.slot = ins_slot;
    if (with_ret) check_head();
    ins_valid = 1'b1; ins_seq = s; ins_pc = it.pc; ins_npc = it.npc; retire = with_ret;
    tick();
    ins_valid = 1'b0; retire = 1'b0;
    if (with_ret) void'(exp_q.pop_front());
    exp_q.push_back(it);
    chk("R3", "tail_seq", tail_seq, s);
    chk("R3", "tail_pc", tail_pc, it.pc);
  endtask

  task automatic ret();
    check_head();
    retire = 1'b1;
    tick();
    retire = 1'b0;
    void'(exp_q.pop_front());
    chk("R5", "occupancy after retire", occupancy, exp_q.size());
  endtask

  task automatic complete_slot(input logic [IDX_W-1:0] s);
    cmpl_valid = 1'b1; cmpl_slot = s;
    tick();
    cmpl_valid = 1'b0;
  endtask

  task automatic squash(input logic [SEQ_W-1:0] b, input bit with_ins, input string req);
    int cnt, n, ex, lowc;
    logic [SEQ_W-1:0] tseq;
    cnt = exp_q.size();
    n = 0;
    for (int i = cnt - 1; i >= 0; i--) begin
      if (exp_q[i].seq > b) n++;
      else break;
    end
    ex = (n + 1 < cnt) ? n + 1 : cnt;
    ex = (ex + SQW - 1) / SQW;
    if (ex < 1) ex = 1;
    tseq = tail_seq;
    squash_req = 1'b1; squash_seq = b;
    if (with_ins) begin
      ins_valid = 1'b1; ins_seq = 16'd777; ins_pc = pc_of(16'd777); ins_npc = pc_of(16'd778);
      retire = 1'b1;
    end
    tick();
    squash_req = 1'b0; ins_valid = 1'b0; retire = 1'b0;
    lowc = 0;
    while (!squash_done && lowc < 40) begin
      lowc++;
      if (cnt > 0) chk("R9", "tail_seq during walk", tail_seq, tseq);
      if (lowc == 2) chk("R9", "tail_squashed during walk", tail_squashed, (n > 0) ? 1 : 0);
      // R10: these must all be dropped while the walk runs.
      ins_valid = 1'b1; ins_seq = 16'd888; ins_pc = pc_of(16'd888); ins_npc = pc_of(16'd889);
      retire = 1'b1; squash_req = 1'b1; squash_seq = 16'd0;
      tick();
      ins_valid = 1'b0; retire = 1'b0; squash_req = 1'b0;
    end
    chk("R8", {req, " squash_done low cycles"}, lowc, ex);
    repeat (n) void'(exp_q.pop_back());
    chk("R7,R10", {req, " occupancy after squash"}, occupancy, exp_q.size());
    if (exp_q.size() > 0) begin
      chk("R7", {req, " tail_seq after squash"}, tail_seq, exp_q[exp_q.size()-1].seq);
      chk("R9", {req, " tail_squashed after reclaim"}, tail_squashed, 0);
    end
    chk("R7", {req, " empty after squash"}, empty, (exp_q.size() == 0) ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1; ins_valid = 1'b0; cmpl_valid = 1'b0; retire = 1'b0; squash_req = 1'b0;
    ins_seq = '0; squash_seq = '0; ins_pc = '0; ins_npc = '0; cmpl_slot = '0;
    fork
      begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "occupancy", occupancy, 0);
        chk("R1", "free_cnt", free_cnt, DEPTH);
        chk("R1", "squash_done", squash_done, 1);
        chk("R1", "head_ready", head_ready, 0);

        ins(16'd10, 1'b0); ins(16'd11, 1'b0); ins(16'd12, 1'b0);
        chk("R2", "occupancy", occupancy, 3);
        chk("R2", "free_cnt", free_cnt, DEPTH - 3);
        chk("R4", "head_ready before completion", head_ready, 0);
        complete_slot(exp_q[1].slot);
        chk("R4", "head_ready after non-head completion", head_ready, 0);
        complete_slot(exp_q[0].slot);
        chk("R4", "head_ready after head completion", head_ready, 1);
        ret();
        chk("R4", "head_ready on completed second entry", head_ready, 1);
        ret();
        chk("R4", "head_ready on incomplete head", head_ready, 0);

        ins(16'd13, 1'b1);
        chk("R6", "occupancy with insert and retire", occupancy, 1);

        for (int s = 14; s <= 20; s++) ins(16'(s), 1'b0);
        chk("R2", "full", full, 1);
        chk("R2", "free_cnt at full", free_cnt, 0);
        chk("R2", "empty at full", empty, 0);

        squash(16'd15, 1'b0, "R7 partial");
        chk("R2", "full after squash", full, 0);
        squash(16'd30, 1'b1, "R11 nothing younger");

        ins(16'd21, 1'b0); ins(16'd22, 1'b0);
        while (exp_q.size() > 0) ret();

        retire = 1'b1;
        tick();
        retire = 1'b0;
        chk("R5", "occupancy after retire on empty", occupancy, 0);
        chk("R5", "empty after retire on empty", empty, 1);
        ins(16'd40, 1'b0);
        chk("R5", "head_seq after retire on empty", head_seq, 16'd40);
        ins(16'd41, 1'b0); ins(16'd42, 1'b0);
        squash(16'd5, 1'b0, "R7 all younger");
        squash(16'd0, 1'b0, "R11 empty buffer");

        for (int s = 50; s < 50 + DEPTH; s++) ins(16'(s), 1'b0);
        chk("R2", "full after wrap fill", full, 1);
        while (exp_q.size() > 0) ret();
        chk("R2", "free_cnt after drain", free_cnt, DEPTH);
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule